// File: doc/BRIEF.md
# Vectored Interrupt Priority Unit

This unit sits behind the source masking of an interrupt controller and turns a set of already-masked interrupt lines into vectored dispatch with nesting. It holds sixteen ranked vector slots. Each slot has a handler address, a source number and an enable bit. It also holds one default address for sources that no enabled slot claims. A request from an upstream controller in a daisy chain is ranked at the default level and carries its own handler address.

The processor acknowledges an interrupt by reading the vector-address port. The read latches the handler address of the highest-ranked eligible request and marks that level as in service. Any write to the same port ends service of the most urgent level that is in service. The request output is raised only when a pending level outranks every level in service, so a more urgent interrupt can preempt a running handler.

A three-state controller tracks nesting depth:
- `ST_IDLE`: nothing is in service.
- `ST_SERVE`: exactly one level is in service.
- `ST_NEST`: two or more levels are in service.

The controller has these transitions:
- ACK: `ST_IDLE`→`ST_SERVE` and `ST_SERVE`→`ST_NEST`.
- An ACK in `ST_NEST` stays in `ST_NEST`.
- EOI: `ST_SERVE`→`ST_IDLE`.
- EOI in `ST_NEST` goes to `ST_SERVE` when one level remains, and stays in `ST_NEST` otherwise.

Top module: `vec_irq_prio`

## Requirements
- R1: After reset, `irq_out` is low, `va_rdata` is 0, the default address is 0, every slot is disabled and no level is in service.
- R2: A slot is pending when its enable bit is set and the source line it names is high. A slot-control write stores the source number in `cfg_wdata[4:0]` and the enable in `cfg_wdata[5]`. With nothing in service, any pending slot drives `irq_out` high.
- R3: A read (`va_rd` high, `va_wr` low) presents on `va_rdata`, from the cycle after the read, the address of the lowest-numbered eligible pending slot. Slot 0 ranks highest.
- R4: An acknowledging read marks the returned level in service. That level no longer drives `irq_out`, even while its source stays high.
- R5: While a level is in service, `irq_out` is high only if a strictly higher-ranked level is pending. Lower-ranked and equal-ranked requests are held back.
- R6: Any write (`va_wr` high), whatever its data, removes the highest-ranked level from the in-service set. `irq_out` is then re-evaluated against the remaining set.
- R7: A high source line that no enabled slot claims forms a request at the default level. The default level ranks below every slot. Acknowledging it returns the default address register, written with `cfg_kind` = 2.
- R8: A daisy-chain request from upstream is ranked at the default level. When it is acknowledged, the address returned is `chain_addr_in` rather than the default address.
- R9: A read with no eligible pending level returns the default address and leaves the in-service set unchanged.
- R10: `va_rdata` holds its value while neither `va_rd` nor `va_wr` is asserted. A write reloads it with the default address.
- R11: When `va_rd` and `va_wr` are high in the same cycle, the write acts and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Masked interrupt source lines |
| chain_req_in | input | 1 | Upstream daisy-chain request |
| chain_addr_in | input | 32 | Upstream handler address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 slot address, 1 slot control, 2 default address |
| cfg_idx | input | 4 | Slot index for slot writes |
| cfg_wdata | input | 32 | Configuration write data |
| va_rd | input | 1 | Vector-address read (acknowledge) |
| va_wr | input | 1 | Vector-address write (end of service) |
| va_rdata | output | 32 | Latched handler address |
| irq_out | output | 1 | Request to the processor |

## Verification
The assertions assume the following about the inputs:
- `va_rd` and `va_wr` are single-cycle strobes sampled at the rising edge.
- `cfg_kind` only carries the three defined codes.
- The reset is held across at least one edge before any strobe.

The stimulus changes all inputs on the falling edge and pulses each strobe for exactly one cycle. It issues the simultaneous read-and-write case only once, on purpose. It compares each latched address through a queue of expected values that a driver fills as it issues reads.

// File: rtl/vip_pkg.sv
package vip_pkg;

    typedef enum logic [1:0] {
        CFG_SLOT_ADDR = 2'd0,
        CFG_SLOT_CTRL = 2'd1,
        CFG_DEF_ADDR  = 2'd2,
        CFG_NONE      = 2'd3
    } cfg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_NEST  = 2'd2
    } svc_state_e;

endpackage

// File: rtl/vip_slot_bank.sv
module vip_slot_bank
    import vip_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int AW    = 32,
    parameter int NSRC  = 32,
    parameter int SRCW  = 5,
    localparam int IDXW = $clog2(NSLOT),
    localparam int NL   = NSLOT + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  cfg_kind_e       cfg_kind,
    input  logic [IDXW-1:0] cfg_idx,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic [NSRC-1:0] src_req,
    input  logic            chain_req,
    output logic [AW-1:0]   slot_addr [NSLOT],
    output logic [AW-1:0]   def_addr,
    output logic [NL-1:0]   pend
);

    logic [SRCW-1:0] src_q [NSLOT];
    logic            en_q  [NSLOT];
    logic [NSRC-1:0] claimed;

    // Per-slot storage and match
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_addr[g] <= '0;
                src_q[g]     <= '0;
                en_q[g]      <= 1'b0;
            end else if (cfg_we && cfg_idx == IDXW'(g)) begin
                if (cfg_kind == CFG_SLOT_ADDR) begin
                    slot_addr[g] <= cfg_wdata;
                end else if (cfg_kind == CFG_SLOT_CTRL) begin
                    src_q[g] <= cfg_wdata[SRCW-1:0];
                    en_q[g]  <= cfg_wdata[SRCW];
                end
            end
        end

        assign pend[g] = en_q[g] && src_req[src_q[g]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            def_addr <= '0;
        end else if (cfg_we && cfg_kind == CFG_DEF_ADDR) begin
            def_addr <= cfg_wdata;
        end
    end

    // Sources claimed by any enabled slot never reach the default level
    always_comb begin
        claimed = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (en_q[i]) begin
                claimed[src_q[i]] = 1'b1;
            end
        end
    end

    assign pend[NSLOT] = (|(src_req & ~claimed)) || chain_req;

    p_cfg_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_kind == CFG_SLOT_CTRL) |=>
            (en_q[$past(cfg_idx)] == $past(cfg_wdata[SRCW])));

endmodule

// File: rtl/vip_prio.sv
module vip_prio #(
    parameter int NSLOT = 16,
    localparam int NL   = NSLOT + 1,
    localparam int IW   = $clog2(NL)
) (
    input  logic [NL-1:0] pend,
    input  logic [NL-1:0] isr,
    output logic          win_vld,
    output logic [IW-1:0] win_idx
);

    int top_isr;

    // Most urgent in-service level; NL when the set is empty
    always_comb begin
        top_isr = NL;
        for (int i = NL - 1; i >= 0; i--) begin
            if (isr[i]) begin
                top_isr = i;
            end
        end
    end

    // Most urgent pending level that outranks everything in service
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (pend[i] && i < top_isr) begin
                win_vld = 1'b1;
                win_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vip_isr_ctrl.sv
module vip_isr_ctrl
    import vip_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int AW    = 32,
    localparam int NL   = NSLOT + 1,
    localparam int IW   = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          wr,
    input  logic          win_vld,
    input  logic [IW-1:0] win_idx,
    input  logic [AW-1:0] win_addr,
    input  logic [AW-1:0] def_addr,
    output logic [NL-1:0] isr,
    output logic [AW-1:0] vaddr_q
);

    svc_state_e    state, state_nx;
    logic [NL-1:0] isr_nx;
    logic [NL-1:0] isr_popped;
    logic          ack, eoi;

    assign eoi        = wr;
    assign ack        = rd && !wr && win_vld;
    assign isr_popped = isr & (isr - NL'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ack) state_nx = ST_SERVE;
            end
            ST_SERVE: begin
                if (eoi)      state_nx = ST_IDLE;
                else if (ack) state_nx = ST_NEST;
            end
            ST_NEST: begin
                if (eoi) begin
                    state_nx = ((isr_popped & (isr_popped - NL'(1))) != '0)
                               ? ST_NEST : ST_SERVE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // In-service set and latched address
    always_comb begin
        isr_nx = isr;
        if (eoi) begin
            isr_nx = isr_popped;
        end else if (ack) begin
            isr_nx = isr | (NL'(1) << win_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr     <= '0;
            vaddr_q <= '0;
        end else begin
            isr <= isr_nx;
            if (eoi) begin
                vaddr_q <= def_addr;
            end else if (rd) begin
                vaddr_q <= win_vld ? win_addr : def_addr;
            end
        end
    end

    p_state_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) == (isr == '0));

    p_ack_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && win_vld) |=> ($countones(isr) == $countones($past(isr)) + 1));

    p_eoi_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && isr != '0) |=> ($countones(isr) + 1 == $countones($past(isr))));

    p_no_elig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && !win_vld) |=> ($stable(isr) && vaddr_q == $past(def_addr)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !wr) |=> $stable(vaddr_q));

endmodule

// File: rtl/vec_irq_prio.sv
module vec_irq_prio
    import vip_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int AW    = 32,
    parameter int NSRC  = 32,
    parameter int SRCW  = 5,
    localparam int IDXW = $clog2(NSLOT),
    localparam int NL   = NSLOT + 1,
    localparam int IW   = $clog2(NL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            chain_req_in,
    input  logic [AW-1:0]   chain_addr_in,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_kind,
    input  logic [IDXW-1:0] cfg_idx,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic            va_rd,
    input  logic            va_wr,
    output logic [AW-1:0]   va_rdata,
    output logic            irq_out
);

    logic [AW-1:0] slot_addr [NSLOT];
    logic [AW-1:0] def_addr;
    logic [AW-1:0] win_addr;
    logic [NL-1:0] pend;
    logic [NL-1:0] isr;
    logic          win_vld;
    logic [IW-1:0] win_idx;

    vip_slot_bank #(.NSLOT(NSLOT), .AW(AW), .NSRC(NSRC), .SRCW(SRCW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind_e'(cfg_kind)),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .src_req   (src_req),
        .chain_req (chain_req_in),
        .slot_addr (slot_addr),
        .def_addr  (def_addr),
        .pend      (pend)
    );

    vip_prio #(.NSLOT(NSLOT)) u_prio (
        .pend    (pend),
        .isr     (isr),
        .win_vld (win_vld),
        .win_idx (win_idx)
    );

    // Default level: upstream address wins over the local default
    always_comb begin
        if (win_idx == IW'(NSLOT)) begin
            win_addr = chain_req_in ? chain_addr_in : def_addr;
        end else begin
            win_addr = slot_addr[win_idx[IDXW-1:0]];
        end
    end

    vip_isr_ctrl #(.NSLOT(NSLOT), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (va_rd),
        .wr       (va_wr),
        .win_vld  (win_vld),
        .win_idx  (win_idx),
        .win_addr (win_addr),
        .def_addr (def_addr),
        .isr      (isr),
        .vaddr_q  (va_rdata)
    );

    assign irq_out = win_vld;

    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && isr[0]) |-> 1'b0 || !isr[0]);

    p_slot0_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (va_rd && !va_wr && pend[0] && !isr[0]) |=> (va_rdata == $past(slot_addr[0])));

endmodule

// File: tb/vec_irq_prio_bench.sv
module vec_irq_prio_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DEF = 32'hDEF0_0000;
    localparam logic [31:0] CH  = 32'hC4A1_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        chain_req_in = 1'b0;
    logic [31:0] chain_addr_in = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        va_rd = 1'b0;
    logic        va_wr = 1'b0;
    logic [31:0] va_rdata;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_irq_prio u_vec_irq_prio (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .chain_req_in(chain_req_in), .chain_addr_in(chain_addr_in),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .va_rd(va_rd), .va_wr(va_wr),
        .va_rdata(va_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] slot_a(int i);
        return 32'h1000_0000 + 32'(i) * 32'h100;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(logic [1:0] k, int idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = 4'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: issue a read and queue its expected address
    task automatic ack(logic [31:0] e, string tag);
        @(negedge clk);
        va_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        va_rd = 1'b0;
        #1;
    endtask

    task automatic eoi();
        @(negedge clk);
        va_wr = 1'b1;
        @(negedge clk);
        va_wr = 1'b0;
        #1;
    endtask

    task automatic set_src(int b, logic v);
        @(negedge clk);
        src_req[b] = v;
        #1;
    endtask

    // Monitor: pop and compare after each plain read
    initial begin
        forever begin
            @(posedge clk);
            if (va_rd && !va_wr) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk("monitor underflow", 32'd1, 32'd0);
                end else begin
                    chk(tag_q.pop_front(), va_rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq after reset", 32'(irq_out), 32'd0);
        chk("R1 rdata after reset", va_rdata, 32'd0);
        ack(32'd0, "R1 default address resets to zero");

        // slots: 0<-src7, 3<-src2, 5<-src9, 15<-src20
        cfg(2'd0, 0, slot_a(0));   cfg(2'd1, 0, 32'h20 | 32'd7);
        cfg(2'd0, 3, slot_a(3));   cfg(2'd1, 3, 32'h20 | 32'd2);
        cfg(2'd0, 5, slot_a(5));   cfg(2'd1, 5, 32'h20 | 32'd9);
        cfg(2'd0, 15, slot_a(15)); cfg(2'd1, 15, 32'h20 | 32'd20);
        cfg(2'd2, 0, DEF);
        #1;
        chk("R2 idle no request", 32'(irq_out), 32'd0);

        set_src(9, 1'b1);
        chk("R2 slot5 pending raises irq", 32'(irq_out), 32'd1);
        ack(slot_a(5), "R3 ack returns slot5");
        chk("R4 in-service slot5 held back", 32'(irq_out), 32'd0);

        set_src(20, 1'b1);
        chk("R5 lower slot15 held back", 32'(irq_out), 32'd0);
        set_src(2, 1'b1);
        chk("R5 higher slot3 nests", 32'(irq_out), 32'd1);
        ack(slot_a(3), "R3 nested ack returns slot3");
        chk("R4 slot3 in service", 32'(irq_out), 32'd0);

        ack(DEF, "R9 no eligible returns default");
        chk("R9 state kept", 32'(irq_out), 32'd0);

        eoi();
        chk("R10 write reloads default", va_rdata, DEF);
        chk("R6 pop slot3 re-exposes it", 32'(irq_out), 32'd1);
        ack(slot_a(3), "R9 state intact, slot3 again");
        repeat (3) @(negedge clk);
        chk("R10 rdata held", va_rdata, slot_a(3));

        set_src(2, 1'b0);
        set_src(9, 1'b0);
        eoi();
        chk("R6 slot5 still blocks slot15", 32'(irq_out), 32'd0);
        eoi();
        chk("R6 empty set exposes slot15", 32'(irq_out), 32'd1);
        ack(slot_a(15), "R3 ack slot15");
        eoi();
        set_src(20, 1'b0);
        chk("R2 nothing pending", 32'(irq_out), 32'd0);

        set_src(30, 1'b1);
        chk("R7 unclaimed source requests", 32'(irq_out), 32'd1);
        ack(DEF, "R7 default address");
        chk("R7 default level in service", 32'(irq_out), 32'd0);
        set_src(7, 1'b1);
        chk("R7 slot0 outranks default", 32'(irq_out), 32'd1);
        ack(slot_a(0), "R3 slot0 over default");
        eoi();
        set_src(7, 1'b0);
        eoi();
        set_src(30, 1'b0);
        chk("R6 all cleared", 32'(irq_out), 32'd0);

        @(negedge clk);
        chain_addr_in = CH;
        chain_req_in  = 1'b1;
        #1;
        chk("R8 chain requests", 32'(irq_out), 32'd1);
        set_src(2, 1'b1);
        ack(slot_a(3), "R8 slot outranks chain");
        eoi();
        set_src(2, 1'b0);
        ack(CH, "R8 chain address passed through");
        chk("R8 chain in service", 32'(irq_out), 32'd0);
        eoi();
        @(negedge clk);
        chain_req_in = 1'b0;
        #1;

        set_src(9, 1'b1);
        ack(slot_a(5), "R11 setup slot5");
        set_src(2, 1'b1);
        @(negedge clk);
        va_rd = 1'b1;
        va_wr = 1'b1;
        @(negedge clk);
        va_rd = 1'b0;
        va_wr = 1'b0;
        #1;
        chk("R11 write wins rdata", va_rdata, DEF);
        chk("R11 write wins irq", 32'(irq_out), 32'd1);

        repeat (2) @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule